// File: doc/BRIEF.md
# Peripheral Interrupt Source Combiner

This block merges several event sources of one peripheral into a single maskable interrupt request for a CPU interrupt controller. Each source owns one pending flag in a status register and one mask bit in an enable register. A hardware event pulse sets its pending flag whether or not the source is enabled. Software clears a flag by writing 0 to that bit.

The request bit is not a latch. It is recomputed every cycle as the OR over all sources of pending AND enabled. An unserviced request therefore disappears when its pending flag or its enable bit is removed. Acknowledge strobes and writes to the request position leave it unchanged. A 3-bit level register, the CPU's current priority and a global interrupt-enable flag together decide whether the request is forwarded to the CPU. When several sources are enabled, the service routine reads the status register to see which ones are pending.

Top module: `irq_comb_top`

## Requirements
- R1: A one-cycle pulse on `evt_i[k]` sets status bit k at the next clock edge, whether or not enable bit k is set.
- R2: A write to the status offset (0) clears each status bit whose data bit is 0 and leaves unchanged each bit whose data bit is 1.
- R3: When a source's event pulse and a software clear of the same status bit fall in the same cycle, the bit ends up set.
- R4: `irq_req_o` is 1 exactly when some bit k has both status k and enable k set. It drops in the cycle in which this stops being true.
- R5: A write to the request offset (3) changes neither `irq_req_o` nor any register.
- R6: A pulse on `ack_i` clears neither the status flags nor `irq_req_o`.
- R7: A further source that raises its flag while `irq_req_o` is already 1 keeps `irq_req_o` at 1, and the status register then shows every pending source.
- R8: `cpu_irq_o` is 1 only when `irq_req_o` is 1, `gie_i` is 1, the level is nonzero, and the level is strictly greater than `cpu_ipl_i`.
- R9: After synchronous reset the status, enable and level registers are 0, and both outputs are 0.
- R10: Reads are combinational. Offset 0 returns status and offset 1 returns enable. Offset 2 returns the level in bits 2:0 with the upper bits 0. Offset 3 returns the request in bit 0 with the upper bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | Per-source event pulses |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| gie_i | input | 1 | Global interrupt enable |
| cpu_ipl_i | input | 3 | Current processor priority level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data |
| irq_req_o | output | 1 | Live interrupt-requested bit |
| cpu_irq_o | output | 1 | Request forwarded to CPU after priority gating |

## Verification
The assertions check several rules on every cycle. Every event pulse leaves its flag set on the next edge, even against a clear in the same cycle. Flags fall only through a status write, so acknowledges never clear them. The level changes only on its own write. The request is never 1 without a matching pending-and-enabled pair, and the forwarded request never appears with a level of 0 or a level that does not exceed the CPU priority. Other behaviours need the bench's scenarios. These are the masked source that sets its flag but raises no request, the request that survives a write of 0 to its offset and an acknowledge, a second source arriving during a live request, and the full table of level, priority and global-enable combinations.

// File: rtl/irq_comb_pkg.sv
package irq_comb_pkg;
    localparam int SRC_N  = 8;
    localparam int LVL_W  = 3;
    localparam int ADDR_W = 2;
    localparam int REG_W  = SRC_N;

    typedef enum logic [ADDR_W-1:0] {
        OFF_STATUS = 2'd0,
        OFF_ENABLE = 2'd1,
        OFF_LEVEL  = 2'd2,
        OFF_REQ    = 2'd3
    } reg_off_e;

    typedef struct packed {
        logic [SRC_N-1:0] en;
        logic [LVL_W-1:0] lvl;
    } cfg_t;

    function automatic logic prio_pass(input logic gie,
                                       input logic [LVL_W-1:0] lvl,
                                       input logic [LVL_W-1:0] ipl);
        return gie && (lvl != '0) && (lvl > ipl);
    endfunction
endpackage

// File: rtl/irq_comb_status.sv
module irq_comb_status
    import irq_comb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] evt,
    input  logic             wr_stat,
    input  logic [SRC_N-1:0] wdata,
    input  logic             ack,
    output logic [SRC_N-1:0] status
);
    logic [SRC_N-1:0] keep_mask;
    logic [SRC_N-1:0] status_nx;

    always_comb begin
        keep_mask = wr_stat ? wdata : '1;
        status_nx = (status & keep_mask) | evt;
    end

    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= status_nx;
    end

    // R1 / R3: an event always leaves its flag set, even against a clear
    a_r3_set_wins: assert property (@(posedge clk) disable iff (rst)
        (evt != '0) |=> ((status & $past(evt)) == $past(evt)));

    // R2: flags only fall through a status write
    a_r2_clear_by_write: assert property (@(posedge clk) disable iff (rst)
        !wr_stat |=> ((status & $past(status)) == $past(status)));

    // R6: acknowledge without a write never drops a flag
    a_r6_ack_keeps: assert property (@(posedge clk) disable iff (rst)
        (ack && !wr_stat) |=> ((status | ~$past(status)) == '1));
endmodule

// File: rtl/irq_comb_cfg.sv
module irq_comb_cfg
    import irq_comb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_lvl,
    input  logic [SRC_N-1:0] wdata,
    output cfg_t             cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else begin
            if (wr_en)  cfg.en  <= wdata;
            if (wr_lvl) cfg.lvl <= wdata[LVL_W-1:0];
        end
    end

    // R5: the level moves only on its own write
    a_r5_level_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_lvl |=> $stable(cfg.lvl));
endmodule

// File: rtl/irq_comb_gate.sv
module irq_comb_gate
    import irq_comb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] status,
    input  cfg_t             cfg,
    input  logic             gie,
    input  logic [LVL_W-1:0] ipl,
    output logic             req,
    output logic             fwd
);
    logic [SRC_N-1:0] hit;

    for (genvar k = 0; k < SRC_N; k++) begin : g_hit
        assign hit[k] = status[k] & cfg.en[k];
    end

    assign req = |hit;
    assign fwd = req & prio_pass(gie, cfg.lvl, ipl);

    // R8: never forward at level 0 or at level not above the CPU priority
    a_r8_prio_gate: assert property (@(posedge clk) disable iff (rst)
        fwd |-> (cfg.lvl != '0 && cfg.lvl > ipl && gie && req));
endmodule

// File: rtl/irq_comb_top.sv
module irq_comb_top
    import irq_comb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_N-1:0]  evt_i,
    input  logic              ack_i,
    input  logic              gie_i,
    input  logic [LVL_W-1:0]  cpu_ipl_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              irq_req_o,
    output logic              cpu_irq_o
);
    reg_off_e         off;
    logic [SRC_N-1:0] status;
    cfg_t             cfg;
    logic             wr_stat, wr_en, wr_lvl;

    assign off     = reg_off_e'(reg_addr_i);
    assign wr_stat = reg_wr_i && off == OFF_STATUS;
    assign wr_en   = reg_wr_i && off == OFF_ENABLE;
    assign wr_lvl  = reg_wr_i && off == OFF_LEVEL;

    irq_comb_status u_stat (
        .clk(clk), .rst(rst), .evt(evt_i), .wr_stat(wr_stat),
        .wdata(reg_wdata_i), .ack(ack_i), .status(status));

    irq_comb_cfg u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_lvl(wr_lvl),
        .wdata(reg_wdata_i), .cfg(cfg));

    irq_comb_gate u_gate (
        .clk(clk), .rst(rst), .status(status), .cfg(cfg), .gie(gie_i),
        .ipl(cpu_ipl_i), .req(irq_req_o), .fwd(cpu_irq_o));

    always_comb begin
        reg_rdata_o = '0;
        unique case (off)
            OFF_STATUS: reg_rdata_o = status;
            OFF_ENABLE: reg_rdata_o = cfg.en;
            OFF_LEVEL:  reg_rdata_o[LVL_W-1:0] = cfg.lvl;
            OFF_REQ:    reg_rdata_o[0] = irq_req_o;
            default:    reg_rdata_o = '0;
        endcase
    end

    // R4: no request without a pending and enabled pair
    a_r4_no_stale_req: assert property (@(posedge clk) disable iff (rst)
        ((status & cfg.en) == '0) |-> !irq_req_o);
endmodule

// File: tb/sim_irq_comb_top.sv
module sim_irq_comb_top;
    import irq_comb_pkg::*;

    logic clk = 0, rst = 1;
    logic [7:0] evt = '0;
    logic ack = 0, gie = 0, wr = 0;
    logic [2:0] ipl = '0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic req, cirq;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_comb_top u0 (
        .clk(clk), .rst(rst), .evt_i(evt), .ack_i(ack), .gie_i(gie),
        .cpu_ipl_i(ipl), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_req_o(req),
        .cpu_irq_o(cirq));

    // {gie, level[2:0], ipl[2:0], expected cpu_irq}
    localparam logic [7:0] PRIO_VEC [8] = '{
        {1'b1, 3'd0, 3'd0, 1'b0},
        {1'b1, 3'd1, 3'd0, 1'b1},
        {1'b1, 3'd3, 3'd3, 1'b0},
        {1'b1, 3'd4, 3'd3, 1'b1},
        {1'b1, 3'd2, 3'd5, 1'b0},
        {1'b0, 3'd7, 3'd0, 1'b0},
        {1'b1, 3'd7, 3'd6, 1'b1},
        {1'b1, 3'd7, 3'd7, 1'b0}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d, input logic [7:0] e);
        @(negedge clk);
        addr = a; wdata = d; wr = 1; evt = e;
        @(posedge clk);
        @(negedge clk);
        wr = 0; evt = '0;
    endtask

    task automatic pulse_evt(input logic [7:0] e);
        @(negedge clk); evt = e;
        @(posedge clk);
        @(negedge clk); evt = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #0.5; d = rdata;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R9 reset state, R10 offsets
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d); chk("R9 reset read", d, 8'h00);
        end
        chk("R9 req after reset", {7'd0, req}, 8'h00);
        chk("R9 cpu irq after reset", {7'd0, cirq}, 8'h00);
        // R1: masked source still sets its flag
        pulse_evt(8'h04);
        rd(2'd0, d); chk("R1 flag set while masked", d, 8'h04);
        chk("R4 no req while masked", {7'd0, req}, 8'h00);
        // R4: enabling raises the request
        reg_write(2'd1, 8'h04, 8'h00);
        chk("R4 req on enable", {7'd0, req}, 8'h01);
        rd(2'd3, d); chk("R10 req offset", d, 8'h01);
        rd(2'd1, d); chk("R10 enable offset", d, 8'h04);
        // R5: writing 0 to request offset ignored
        reg_write(2'd3, 8'h00, 8'h00);
        chk("R5 req after write 0", {7'd0, req}, 8'h01);
        rd(2'd0, d); chk("R5 status untouched", d, 8'h04);
        // R6: acknowledge clears nothing
        @(negedge clk); ack = 1;
        @(posedge clk); @(negedge clk); ack = 0;
        rd(2'd0, d); chk("R6 status after ack", d, 8'h04);
        chk("R6 req after ack", {7'd0, req}, 8'h01);
        // R7: another source during live request
        reg_write(2'd1, 8'h24, 8'h00);
        pulse_evt(8'h20);
        chk("R7 req stays", {7'd0, req}, 8'h01);
        rd(2'd0, d); chk("R7 both pending", d, 8'h24);
        // R2: clear bit2 only
        reg_write(2'd0, 8'hFB, 8'h00);
        rd(2'd0, d); chk("R2 selective clear", d, 8'h20);
        chk("R4 req via bit5", {7'd0, req}, 8'h01);
        // R3: clear bit5 while event on bit5
        reg_write(2'd0, 8'hDF, 8'h20);
        rd(2'd0, d); chk("R3 set beats clear", d, 8'h20);
        // R8: priority table with request live
        foreach (PRIO_VEC[i]) begin
            reg_write(2'd2, {5'd0, PRIO_VEC[i][6:4]}, 8'h00);
            @(negedge clk);
            gie = PRIO_VEC[i][7]; ipl = PRIO_VEC[i][3:1];
            #0.5;
            chk("R8 priority gate", {7'd0, cirq}, {7'd0, PRIO_VEC[i][0]});
        end
        // R10: level readback upper bits zero
        reg_write(2'd2, 8'hFF, 8'h00);
        rd(2'd2, d); chk("R10 level offset", d, 8'h07);
        // R4: dropping enable removes request without ack
        reg_write(2'd1, 8'h04, 8'h00);
        chk("R4 drop on disable", {7'd0, req}, 8'h00);
        chk("R8 no fwd without req", {7'd0, cirq}, 8'h00);
        rd(2'd0, d); chk("R4 flag kept", d, 8'h20);
        reg_write(2'd0, 8'h00, 8'h00);
        rd(2'd0, d); chk("R2 clear all", d, 8'h00);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule